// File: doc/BRIEF.md
# Dual-Channel Interrupt Pending Mirror

This block keeps the interrupt state of a two-channel disk controller. Each channel has one pending flag, and that flag appears in two places in configuration space. The first copy is a legacy location, which is a separate byte for each channel. The second copy sits in a shared mode byte, next to one block (mask) bit for each channel. The block keeps both copies equal. It combines the channels into a single level-sensitive host interrupt.

The host reaches the three bytes through a word-wide configuration port, with a byte enable for each lane. A pending bit cannot be set by software, only cleared by writing a one to it. Clearing either copy clears the other copy in the same cycle. A change on a channel's request level writes the new level into both copies. All other bits of the three bytes are ordinary storage.

Top module: `imr_mirror`

## Requirements
- R1: After reset every pending bit, block bit and storage bit reads as zero, and `host_irq` is low.
- R2: A rising edge on `ch_req[c]` sets the channel's pending flag in both copies. Channel 0 uses byte 0x50 bit 2 and byte 0x71 bit 2. Channel 1 uses byte 0x57 bit 4 and byte 0x71 bit 3. The new value is visible right after the clock edge that samples the change.
- R3: A falling edge on `ch_req[c]` clears the channel's pending flag in both copies.
- R4: Writing a one to a legacy pending bit (0x50 bit 2 or 0x57 bit 4) clears that flag in both copies. Writing a zero there changes nothing.
- R5: Writing a one to a pending bit of byte 0x71 (bit 2 or bit 3) clears the flag there and in the legacy copy.
- R6: No host write can set a pending bit, in either copy.
- R7: `host_irq` = (pend0 AND NOT blk0) OR (pend1 AND NOT blk1). The block bits are byte 0x71 bit 4 (channel 0) and bit 5 (channel 1). Both are read/write.
- R8: Every other bit of bytes 0x50, 0x57 and 0x71 is plain read/write storage that the mirroring does not touch. A lane whose byte enable is low is not written.
- R9: Only a change of request level acts on a pending flag. A request held high does not set the flag again after a host clear. When a request change and a clearing write land in the same cycle, the request level wins.
- R10: Reads of any other word return zero, and writes to any other word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_waddr | input | ADDR_W | Byte address of the write word (low bits ignored) |
| cfg_wdata | input | DATA_W | Write data, byte lanes little-endian |
| cfg_wbe | input | DATA_W/8 | Byte enables for the write |
| cfg_raddr | input | ADDR_W | Byte address of the read word (low bits ignored) |
| cfg_rdata | output | DATA_W | Read data for the addressed word, combinational |
| ch_req | input | 2 | Channel interrupt request levels |
| host_irq | output | 1 | Level host interrupt |

## Verification
Every result is due after exactly one clock edge. That edge is the first one that samples a write strobe or a changed request level. The read port and `host_irq` follow the registers with no further delay.

The bench drives its stimulus at a falling edge and lets one rising edge pass. It then reads back at the following falling edge, so every check lands in the first cycle where the result is due. The same-cycle priority case drives a request change and a clearing write at the same falling edge. This places both on one rising edge.

// File: rtl/imr_pkg.sv
package imr_pkg;
   localparam int unsigned NCH    = 2;
   localparam int unsigned NREG   = 3;
   localparam int unsigned REG_MODE = 2;
   // byte offsets: legacy ch0, legacy ch1, shared mode byte
   localparam int unsigned REG_OFS [NREG] = '{32'h50, 32'h57, 32'h71};
   // bits held as plain storage (pending positions excluded)
   localparam logic [7:0]  REG_KEEP [NREG] = '{8'hFB, 8'hEF, 8'hF3};
   // legacy pending bit position per channel
   localparam int unsigned LEG_BIT [NCH] = '{2, 4};
   localparam int unsigned MODE_PEND_LSB = 2;
   localparam int unsigned MODE_BLK_LSB  = 4;
endpackage

// File: rtl/imr_sel.sv
module imr_sel #(
   parameter int unsigned AW   = 6,
   parameter int unsigned WORD = 0
) (
   input  logic [AW-1:0] waddr,
   input  logic [AW-1:0] raddr,
   input  logic          wr,
   input  logic          lane_be,
   output logic          whit,
   output logic          rhit
);
   localparam logic [AW-1:0] WORD_V = AW'(WORD);

   assign whit = wr && lane_be && (waddr == WORD_V);
   assign rhit = (raddr == WORD_V);
endmodule

// File: rtl/imr_store.sv
module imr_store #(
   parameter logic [7:0] KEEP = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wbyte,
   output logic [7:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wbyte & KEEP;
   end

   p_store_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/imr_chan.sv
module imr_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic leg_wr,
   input  logic leg_clr,
   input  logic mode_wr,
   input  logic mode_clr,
   input  logic sync_leg,
   output logic leg_q,
   output logic mode_q
);
   logic req_q;
   logic leg_c, mode_c;
   logic leg_n, mode_n;

   always_comb begin
      leg_c  = leg_q  & ~(leg_wr  & leg_clr);
      mode_c = mode_q & ~(mode_wr & mode_clr);
      leg_n  = leg_q;
      mode_n = mode_q;
      if (sync_leg && mode_wr) begin
         leg_n  = leg_c & mode_c;
         mode_n = leg_c & mode_c;
      end else if (sync_leg) begin
         leg_n  = leg_c;
         mode_n = leg_c;
      end else if (mode_wr) begin
         leg_n  = mode_c;
         mode_n = mode_c;
      end
      if (req != req_q) begin
         leg_n  = req;
         mode_n = req;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         leg_q  <= 1'b0;
         mode_q <= 1'b0;
      end else begin
         req_q  <= req;
         leg_q  <= leg_n;
         mode_q <= mode_n;
      end
   end

   p_copies_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
      leg_q == mode_q);
   p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !req_q) |=> (leg_q && mode_q));
   p_req_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && req_q) |=> (!leg_q && !mode_q));
   p_no_host_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && req == req_q) |=> !mode_q);
   p_leg_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (leg_wr && leg_clr && req == req_q) |=> (!mode_q && !leg_q));
endmodule

// File: rtl/imr_mirror.sv
module imr_mirror #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [ADDR_W-1:0]     cfg_waddr,
   input  logic [DATA_W-1:0]     cfg_wdata,
   input  logic [DATA_W/8-1:0]   cfg_wbe,
   input  logic [ADDR_W-1:0]     cfg_raddr,
   output logic [DATA_W-1:0]     cfg_rdata,
   input  logic [1:0]            ch_req,
   output logic                  host_irq
);
   import imr_pkg::*;

   localparam int unsigned LANES  = DATA_W / 8;
   localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int unsigned WAW    = ADDR_W - LANE_W;

   if (DATA_W < 16 || (DATA_W % 8) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("imr_mirror: DATA_W must be a power-of-two byte count of at least 16 bits");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("imr_mirror: ADDR_W must reach offset 0x71");
   end

   logic [NREG-1:0] whit, rhit;
   logic [7:0]      wbyte [NREG];
   logic [7:0]      sq    [NREG];
   logic [7:0]      rbyte [NREG];
   logic [NCH-1:0]  leg_p, mode_p, blk;
   logic            unused_bits;

   assign unused_bits = ^{cfg_wdata, cfg_wbe, cfg_waddr[LANE_W-1:0], cfg_raddr[LANE_W-1:0]};

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam int unsigned LANE = REG_OFS[g] % LANES;
      localparam int unsigned WORD = REG_OFS[g] / LANES;

      imr_sel #(.AW(WAW), .WORD(WORD)) u_sel (
         .waddr   (cfg_waddr[ADDR_W-1:LANE_W]),
         .raddr   (cfg_raddr[ADDR_W-1:LANE_W]),
         .wr      (cfg_wr),
         .lane_be (cfg_wbe[LANE]),
         .whit    (whit[g]),
         .rhit    (rhit[g])
      );

      assign wbyte[g] = cfg_wdata[LANE*8 +: 8];

      imr_store #(.KEEP(REG_KEEP[g])) u_store (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (whit[g]),
         .wbyte (wbyte[g]),
         .q     (sq[g])
      );
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      imr_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .req      (ch_req[c]),
         .leg_wr   (whit[c]),
         .leg_clr  (wbyte[c][LEG_BIT[c]]),
         .mode_wr  (whit[REG_MODE]),
         .mode_clr (wbyte[REG_MODE][MODE_PEND_LSB+c]),
         .sync_leg (|whit[NCH-1:0]),
         .leg_q    (leg_p[c]),
         .mode_q   (mode_p[c])
      );
      assign blk[c] = sq[REG_MODE][MODE_BLK_LSB+c];
   end

   always_comb begin
      for (int g = 0; g < NREG; g++) rbyte[g] = sq[g];
      for (int c = 0; c < NCH; c++) begin
         rbyte[c][LEG_BIT[c]]                  = leg_p[c];
         rbyte[REG_MODE][MODE_PEND_LSB + c]    = mode_p[c];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int g = 0; g < NREG; g++) begin
         if (rhit[g])
            cfg_rdata = cfg_rdata | (DATA_W'(rbyte[g]) << ((REG_OFS[g] % LANES) * 8));
      end
   end

   assign host_irq = |(mode_p & ~blk);

   p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> (|mode_p));
   p_blocked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (&blk) |-> !host_irq);
endmodule

// File: tb/sim_imr_mirror.sv
`timescale 1ns/1ps
module sim_imr_mirror;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_waddr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [3:0]  cfg_wbe = '0;
   logic [7:0]  cfg_raddr = '0;
   logic [31:0] cfg_rdata;
   logic [1:0]  ch_req = '0;
   logic        host_irq;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   imr_mirror u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
      .cfg_wdata(cfg_wdata), .cfg_wbe(cfg_wbe), .cfg_raddr(cfg_raddr),
      .cfg_rdata(cfg_rdata), .ch_req(ch_req), .host_irq(host_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      cfg_raddr = a;
      #1;
      chk(req, cfg_rdata, exp);
   endtask

   task automatic irqchk(input string req, input logic exp);
      chk(req, {31'b0, host_irq}, {31'b0, exp});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ch_req = '0; cfg_wr = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      cfg_waddr = a; cfg_wdata = d; cfg_wbe = be; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_req(input int c, input logic v);
      ch_req[c] = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      rdchk("R1 legacy0", 8'h50, 32'h0);
      rdchk("R1 legacy1", 8'h54, 32'h0);
      rdchk("R1 mode", 8'h70, 32'h0);
      irqchk("R1 irq", 1'b0);
   endtask

   task automatic t_req_edges();
      do_reset();
      set_req(0, 1'b1);
      rdchk("R2 ch0 legacy", 8'h50, 32'h4);
      rdchk("R2 ch0 mode", 8'h70, 32'h0400);
      irqchk("R2 irq", 1'b1);
      set_req(1, 1'b1);
      rdchk("R2 ch1 legacy", 8'h54, 32'h1000_0000);
      rdchk("R2 both mode", 8'h70, 32'h0C00);
      set_req(0, 1'b0);
      rdchk("R3 ch0 legacy", 8'h50, 32'h0);
      rdchk("R3 ch0 mode", 8'h70, 32'h0800);
      set_req(1, 1'b0);
      rdchk("R3 ch1 legacy", 8'h54, 32'h0);
      rdchk("R3 mode clear", 8'h70, 32'h0);
      irqchk("R3 irq", 1'b0);
   endtask

   task automatic t_legacy_clear();
      do_reset();
      set_req(0, 1'b1);
      set_req(1, 1'b1);
      wr(8'h50, 32'h0, 4'h1);
      rdchk("R4 zero write", 8'h50, 32'h4);
      wr(8'h50, 32'h4, 4'h1);
      rdchk("R4 ch0 legacy", 8'h50, 32'h0);
      rdchk("R4 ch0 mode", 8'h70, 32'h0800);
      irqchk("R4 irq ch1", 1'b1);
      wr(8'h54, 32'h1000_0000, 4'h8);
      rdchk("R4 ch1 legacy", 8'h54, 32'h0);
      rdchk("R4 ch1 mode", 8'h70, 32'h0);
      @(negedge clk); @(negedge clk); @(negedge clk);
      rdchk("R9 held req no reset", 8'h70, 32'h0);
      irqchk("R9 irq", 1'b0);
   endtask

   task automatic t_mode_clear();
      do_reset();
      set_req(0, 1'b1);
      set_req(1, 1'b1);
      wr(8'h70, 32'h0800, 4'h2);
      rdchk("R5 mode", 8'h70, 32'h0400);
      rdchk("R5 ch1 legacy", 8'h54, 32'h0);
      rdchk("R5 ch0 legacy", 8'h50, 32'h4);
      wr(8'h70, 32'h0400, 4'h2);
      rdchk("R5 ch0 legacy clr", 8'h50, 32'h0);
      rdchk("R5 mode clr", 8'h70, 32'h0);
   endtask

   task automatic t_no_set();
      do_reset();
      wr(8'h50, 32'h4, 4'h1);
      wr(8'h54, 32'h1000_0000, 4'h8);
      wr(8'h70, 32'h0C00, 4'h2);
      rdchk("R6 legacy0", 8'h50, 32'h0);
      rdchk("R6 legacy1", 8'h54, 32'h0);
      rdchk("R6 mode", 8'h70, 32'h0);
      irqchk("R6 irq", 1'b0);
   endtask

   task automatic t_block();
      do_reset();
      wr(8'h70, 32'h1000, 4'h2);
      rdchk("R7 blk0 stored", 8'h70, 32'h1000);
      set_req(0, 1'b1);
      irqchk("R7 ch0 blocked", 1'b0);
      rdchk("R7 pend behind block", 8'h70, 32'h1400);
      set_req(1, 1'b1);
      irqchk("R7 ch1 open", 1'b1);
      wr(8'h70, 32'h3000, 4'h2);
      irqchk("R7 both blocked", 1'b0);
      rdchk("R7 mode", 8'h70, 32'h3C00);
      wr(8'h70, 32'h0000, 4'h2);
      irqchk("R7 unblocked", 1'b1);
   endtask

   task automatic t_storage();
      do_reset();
      wr(8'h50, 32'hFFFF_FFFF, 4'h1);
      rdchk("R8 legacy0 store", 8'h50, 32'h0000_00FB);
      wr(8'h50, 32'h0, 4'h0);
      rdchk("R8 no enable", 8'h50, 32'h0000_00FB);
      wr(8'h54, 32'hFF00_0000, 4'h8);
      rdchk("R8 legacy1 store", 8'h54, 32'hEF00_0000);
      wr(8'h70, 32'h0000_C300, 4'h2);
      rdchk("R8 mode store", 8'h70, 32'h0000_C300);
      set_req(0, 1'b1);
      rdchk("R8 legacy0 with pend", 8'h50, 32'h0000_00FF);
      rdchk("R8 mode with pend", 8'h70, 32'h0000_C700);
      irqchk("R8 irq", 1'b1);
   endtask

   task automatic t_priority();
      do_reset();
      ch_req[0] = 1'b1;
      wr(8'h50, 32'h4, 4'h1);
      rdchk("R9 request wins", 8'h50, 32'h4);
      wr(8'h50, 32'h4, 4'h1);
      rdchk("R9 cleared", 8'h50, 32'h0);
   endtask

   task automatic t_other();
      do_reset();
      set_req(0, 1'b1);
      wr(8'h60, 32'hFFFF_FFFF, 4'hF);
      rdchk("R10 other word", 8'h60, 32'h0);
      rdchk("R10 word zero", 8'h00, 32'h0);
      rdchk("R10 word 0x74", 8'h74, 32'h0);
      rdchk("R10 pend kept", 8'h50, 32'h4);
      rdchk("R10 mode kept", 8'h70, 32'h0400);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_req_edges();
      t_legacy_clear();
      t_mode_clear();
      t_no_set();
      t_block();
      t_storage();
      t_priority();
      t_other();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule